// File: doc/BRIEF.md
# SPI Master with Threshold Interrupts

This block is a memory-mapped SPI master. Software writes bytes into a four-entry transmit queue and reads received bytes from a four-entry receive queue. A programmable divider sets the serial clock rate. The block shifts each byte out MSB first in SPI mode 0: the clock idles low, data is sampled on the rising edge and changes after the falling edge. It drives an active-low chip select and raises two level interrupts.

The transmit interrupt fires once a programmed number of bytes has left the shifter. The receive interrupt fires once a programmed number of bytes is waiting in the receive queue. Each queue has a flush bit that stays set until software clears it. Other control bits select continuous transfers with chip select held low, internal loopback, a zero-fill option, and whether transfers start from queued data or from reads of the receive register.

The serial engine is a five-state machine:
- IDLE: chip select high. Moves to LEAD when a byte is available.
- LEAD: chip select low, clock low, MSB presented. Moves to HIGH after a half period.
- HIGH: clock high. Moves to LOW after a half period while bits remain. After the eighth bit it moves to LEAD if continuous mode has another byte ready, otherwise to STALL.
- LOW: clock low, next bit presented. Moves to HIGH after a half period.
- STALL: chip select high for one full serial clock period, then back to IDLE.

Top module: `spim_top`

## Requirements
- R1: After reset the divider register (address 2) reads 0x1B and the control register (address 3) reads 0x0000. A read of the receive register (address 0) returns 0x00. cs_n is high, sclk is low, and both interrupts are low.
- R2: Bytes go out MSB first in SPI mode 0. Each sclk high phase and each low phase inside a transfer lasts divider+1 system clocks.
- R3: With interrupt mode N in control bits 15:14, tx_irq goes high once N+1 bytes have completed since the last write to the transmit register (address 1). It stays high until the next such write.
- R4: rx_irq is high exactly while the receive queue holds at least N+1 bytes. In mode 3 this means the queue is full.
- R5: The receive queue keeps four bytes in arrival order. Each read of address 0 returns the oldest byte and removes it. A read of an empty queue returns 0x00.
- R6: While control bit 13 is set, the transmit queue is emptied within one clock and writes to address 1 are discarded.
- R7: While bit 13 is set, a started transfer sends a fill byte. The fill byte is 0x00 when control bit 7 is set, and the last byte sent otherwise.
- R8: While control bit 12 is set, the receive queue is emptied within one clock, received bytes are dropped, and rx_irq stays low.
- R9: Control bit 6 chooses how transfers start. When it is 1, a transfer starts whenever the transmit queue holds data. When it is 0, queued data waits, and a read of address 0 while bit 12 is set starts one transfer.
- R10: With control bit 11 set, queued bytes go back to back and cs_n stays low until the queue runs empty. With bit 11 clear, cs_n rises after every byte and stays high for 2×(divider+1)+1 clocks before the next byte.
- R11: With control bit 10 set, the receiver takes the transmitted bit in place of the miso pin.
- R12: The transmit queue holds four bytes. Writes to a full queue are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of address 0 removes a byte) |
| addr | input | 2 | Register select: 0 receive, 1 transmit, 2 divider, 3 control |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |
| tx_irq | output | 1 | Transmit threshold interrupt |
| rx_irq | output | 1 | Receive threshold interrupt |

## Verification
The bench sweeps all four interrupt modes against one to four bytes. A design with an off-by-one threshold would raise an interrupt one byte early or late, and a receive interrupt that fails to track reads would stay high after the queue has drained. It sweeps several divider values and measures every clock phase, which catches a half period of divider cycles instead of divider+1. It also checks the width of the chip-select gap in single-byte mode, and confirms that chip select does not rise in continuous mode. Overfilled and flushed queues are driven to show that discarded writes stay out. The fill-byte test covers both choices, including a fill that repeats the last byte sent.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int unsigned BYTE_W = 8;

    // register map
    localparam logic [1:0] A_RXD  = 2'd0;
    localparam logic [1:0] A_TXD  = 2'd1;
    localparam logic [1:0] A_DIV  = 2'd2;
    localparam logic [1:0] A_CTRL = 2'd3;

    // control field positions
    localparam int unsigned C_MODE_LO = 14;
    localparam int unsigned C_TXFL    = 13;
    localparam int unsigned C_RXFL    = 12;
    localparam int unsigned C_CONT    = 11;
    localparam int unsigned C_LOOP    = 10;
    localparam int unsigned C_ZFILL   = 7;
    localparam int unsigned C_QSTART  = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_STALL
    } shf_state_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [LW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full, empty, do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rp];

    function automatic logic [AW-1:0] nxt_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else if (flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= nxt_ptr(wp);
            if (do_pop)  rp <= nxt_ptr(rp);
            unique case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // R5/R12: a push into a full queue leaves its level unchanged
    a_r12_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (level == $past(level)));
    // R6/R8: a flush leaves the queue empty on the next cycle
    a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0));
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
#(
    parameter int unsigned DIV_W = 8,
    localparam int unsigned CW   = DIV_W + 1,
    localparam int unsigned BCW  = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div,
    input  logic              cont,
    input  logic              loop_en,
    input  logic              start_ok,
    input  logic [BYTE_W-1:0] start_byte,
    input  logic              miso,
    output logic              take,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n
);
    shf_state_t        state, nxt;
    logic [CW-1:0]     cnt;
    logic [BCW-1:0]    bitc;
    logic [BYTE_W-1:0] tx_sh, rx_sh;
    logic              half_end, stall_end, last_bit, miso_eff;

    assign half_end  = (cnt == {1'b0, div});
    assign stall_end = (cnt == {div, 1'b1});
    assign last_bit  = (bitc == BCW'(BYTE_W - 1));
    assign miso_eff  = loop_en ? tx_sh[BYTE_W-1] : miso;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start_ok) nxt = ST_LEAD;
            ST_LEAD:  if (half_end) nxt = ST_HIGH;
            ST_HIGH:  if (half_end) begin
                          if (!last_bit)            nxt = ST_LOW;
                          else if (cont && start_ok) nxt = ST_LEAD;
                          else                       nxt = ST_STALL;
                      end
            ST_LOW:   if (half_end) nxt = ST_HIGH;
            ST_STALL: if (stall_end) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        sclk = (state == ST_HIGH);
        cs_n = (state == ST_IDLE) || (state == ST_STALL);
        mosi = tx_sh[BYTE_W-1];
        done = (state == ST_HIGH) && half_end && last_bit;
        take = ((state == ST_IDLE) && start_ok) || (done && cont && start_ok);
        rx_byte = rx_sh;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            bitc  <= '0;
            tx_sh <= '0;
            rx_sh <= '0;
        end else begin
            cnt <= (nxt != state) ? '0 : cnt + 1'b1;
            if (take) begin
                tx_sh <= start_byte;
                bitc  <= '0;
            end else if ((state == ST_HIGH) && half_end && !last_bit) begin
                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                bitc  <= bitc + 1'b1;
            end
            if ((nxt == ST_HIGH) && (state != ST_HIGH))
                rx_sh <= {rx_sh[BYTE_W-2:0], miso_eff};
        end
    end

    // R2: the serial clock only toggles inside a selected transfer
    a_r2_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);
    // R2: data does not change while the clock is high
    a_r2_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));
    // R10: a byte boundary without continuous mode releases chip select
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cont) |=> cs_n);
endmodule

// File: rtl/spim_top.sv
module spim_top
    import spim_pkg::*;
#(
    parameter int unsigned DEPTH     = 4,
    parameter int unsigned DIV_W     = 8,
    parameter logic [7:0]  DIV_RESET = 8'h1B,
    localparam int unsigned LW       = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [1:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic        cs_n,
    output logic        tx_irq,
    output logic        rx_irq
);
    logic [15:0]       ctrl_q;
    logic [DIV_W-1:0]  div_q;
    logic [BYTE_W-1:0] last_tx, tx_head, rx_head, rx_byte, start_byte, fill;
    logic [LW-1:0]     tx_level, rx_level;
    logic [LW-1:0]     done_cnt;
    logic [1:0]        mode;
    logic              tx_fl, rx_fl, have_data, start_ok, take, done, rd_pend;
    logic              wr_tx, rd_rx;

    assign mode      = ctrl_q[C_MODE_LO +: 2];
    assign tx_fl     = ctrl_q[C_TXFL];
    assign rx_fl     = ctrl_q[C_RXFL];
    assign wr_tx     = wr_en && (addr == A_TXD);
    assign rd_rx     = rd_en && (addr == A_RXD);
    assign have_data = (tx_level != '0) && !tx_fl;
    assign start_ok  = (ctrl_q[C_QSTART] && have_data) || rd_pend;
    assign fill      = ctrl_q[C_ZFILL] ? '0 : last_tx;
    assign start_byte = have_data ? tx_head : fill;

    spim_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_fl),
        .push(wr_tx), .wdata(wdata[BYTE_W-1:0]),
        .pop(take && have_data), .head(tx_head), .level(tx_level));

    spim_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_fl),
        .push(done), .wdata(rx_byte),
        .pop(rd_rx), .head(rx_head), .level(rx_level));

    spim_shifter #(.DIV_W(DIV_W)) u_shf (
        .clk(clk), .rst_n(rst_n), .div(div_q),
        .cont(ctrl_q[C_CONT]), .loop_en(ctrl_q[C_LOOP]),
        .start_ok(start_ok), .start_byte(start_byte), .miso(miso),
        .take(take), .done(done), .rx_byte(rx_byte),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n));

    // registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            div_q    <= DIV_W'(DIV_RESET);
            last_tx  <= '0;
            rd_pend  <= 1'b0;
            done_cnt <= '0;
        end else begin
            if (wr_en && (addr == A_CTRL)) ctrl_q <= wdata;
            if (wr_en && (addr == A_DIV))  div_q  <= wdata[DIV_W-1:0];
            if (take) last_tx <= start_byte;
            if (take)
                rd_pend <= 1'b0;
            else if (rd_rx && rx_fl && !ctrl_q[C_QSTART])
                rd_pend <= 1'b1;
            if (wr_tx)
                done_cnt <= '0;
            else if (done && (done_cnt != LW'(DEPTH)))
                done_cnt <= done_cnt + 1'b1;
        end
    end

    // interrupts and read mux
    always_comb begin
        tx_irq = (done_cnt > LW'(mode));
        rx_irq = !rx_fl && (rx_level > LW'(mode));
        unique case (addr)
            A_RXD:   rdata = {8'h00, (rx_level == '0) ? 8'h00 : rx_head};
            A_DIV:   rdata = 16'(div_q);
            A_CTRL:  rdata = ctrl_q;
            default: rdata = '0;
        endcase
    end

    // R3: a write to the transmit register clears the transmit interrupt
    a_r3_tx_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tx |=> !tx_irq);
    // R4: a receive interrupt needs data in the receive queue
    a_r4_rx_irq_data: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (rx_level != '0));
    // R8: a held receive flush keeps the queue empty
    a_r8_rx_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fl && $past(rx_fl)) |-> (rx_level == '0));
    // R6: a held transmit flush keeps the queue empty
    a_r6_tx_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_fl && $past(tx_fl)) |-> (tx_level == '0));
endmodule

// File: tb/spim_top_tb.sv
module spim_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] QS = 16'h0040, ZF = 16'h0080, LP = 16'h0400,
                            CT = 16'h0800, RF = 16'h1000, TF = 16'h2000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [15:0] wdata = '0, rdata;
    logic sclk, mosi, miso, cs_n, tx_irq, rx_irq;

    int n_chk = 0, n_bad = 0, cyc = 0;

    spim_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .sclk(sclk),
        .mosi(mosi), .miso(miso), .cs_n(cs_n), .tx_irq(tx_irq), .rx_irq(rx_irq));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pat(input int i);
        return 8'(8'hC3 ^ (i * 29));
    endfunction

    // slave model, SPI mode 0, MSB first
    logic [7:0] sl_sh = 8'h00, sl_rx = 8'h00;
    logic [7:0] got [256];
    int sl_bits = 0, sl_cnt = 0;
    assign miso = sl_sh[7];
    always @(posedge sclk) begin
        sl_rx = {sl_rx[6:0], mosi};
        sl_bits = sl_bits + 1;
        if (sl_bits == 8) begin
            got[sl_cnt % 256] = sl_rx;
            sl_cnt = sl_cnt + 1;
            sl_bits = 0;
        end
    end
    always @(negedge cs_n or negedge sclk) begin
        if (sl_bits == 0) sl_sh = pat(sl_cnt);
        else              sl_sh = {sl_sh[6:0], 1'b0};
    end

    // waveform monitor
    int hi_run = 0, lo_run = 0, hi_min = 999, hi_max = 0, lo_min = 999, lo_max = 0;
    int cs_hi_run = 0, cs_gap = 0, cs_rises = 0;
    logic prev_cs = 1'b1;
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (sclk) hi_run = hi_run + 1;
        else if (hi_run != 0) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
            hi_run = 0;
        end
        if (cs_n) lo_run = 0;
        else if (!sclk) lo_run = lo_run + 1;
        else if (lo_run != 0) begin
            if (lo_run < lo_min) lo_min = lo_run;
            if (lo_run > lo_max) lo_max = lo_run;
            lo_run = 0;
        end
        if (cs_n && !prev_cs) cs_rises = cs_rises + 1;
        if (cs_n) cs_hi_run = cs_hi_run + 1;
        else if (prev_cs) begin cs_gap = cs_hi_run; cs_hi_run = 0; end
        prev_cs = cs_n;
    end

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        while (cyc < 150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_bytes(input int target);
        int lim = 0;
        while (sl_cnt < target && lim < 20000) begin @(negedge clk); lim++; end
        idle(40);
    endtask

    initial begin
        logic [15:0] d;
        int base;
        idle(3); rst_n = 1'b1; idle(2);

        // R1 reset state
        rd(2'd2, d); chk("R1 div", d, 16'h001B);
        rd(2'd3, d); chk("R1 ctrl", d, 16'h0000);
        rd(2'd0, d); chk("R1 rx", d, 16'h0000);
        chk("R1 pins", {cs_n, sclk, tx_irq, rx_irq}, 4'b1000);

        // R2/R11 divider sweep with loopback
        for (int k = 0; k < 5; k++) begin
            int dv;
            dv = (k == 4) ? 9 : ((k == 3) ? 4 : k);
            wr(2'd2, 16'(dv));
            wr(2'd3, QS | LP);
            hi_min = 999; hi_max = 0; lo_min = 999; lo_max = 0;
            base = sl_cnt;
            wr(2'd1, 16'(8'h5A ^ dv));
            wait_bytes(base + 1);
            chk("R2 hi min", hi_min, dv + 1); chk("R2 hi max", hi_max, dv + 1);
            chk("R2 lo min", lo_min, dv + 1); chk("R2 lo max", lo_max, dv + 1);
            chk("R2 msb-first mosi", got[base % 256], 8'h5A ^ dv);
            rd(2'd0, d); chk("R11 loopback rx", d, 8'h5A ^ dv);
        end

        // R3/R4 threshold sweep, div 0, pins from slave
        wr(2'd2, 16'd0);
        for (int m = 0; m < 4; m++) begin
            for (int k = 1; k <= 4; k++) begin
                wr(2'd3, QS | 16'(m << 14));
                base = sl_cnt;
                for (int j = 0; j < k; j++) wr(2'd1, 16'(8'h10 + j));
                wait_bytes(base + k);
                chk("R3 tx_irq", tx_irq, (k >= m + 1) ? 1 : 0);
                chk("R4 rx_irq", rx_irq, (k >= m + 1) ? 1 : 0);
                for (int j = 0; j < k; j++) begin
                    rd(2'd0, d);
                    chk("R5 rx order", d, pat(base + j));
                    chk("R4 rx_irq drain", rx_irq, (k - j - 1 >= m + 1) ? 1 : 0);
                end
                rd(2'd0, d); chk("R5 empty read", d, 0);
                if (k >= m + 1) begin
                    wr(2'd3, 16'h0000);
                    wr(2'd1, 16'h0000);
                    chk("R3 tx_irq clear", tx_irq, 0);
                    wr(2'd3, TF); wr(2'd3, 16'h0000);
                end
            end
        end

        // R10 continuous vs single
        wr(2'd2, 16'd1);
        wr(2'd3, QS | CT);
        base = sl_cnt; cs_rises = 0;
        for (int j = 0; j < 3; j++) wr(2'd1, 16'(8'hA0 + j));
        wait_bytes(base + 3);
        chk("R10 cont cs rises", cs_rises, 1);
        chk("R10 cont data", got[(base + 2) % 256], 8'hA2);
        for (int j = 0; j < 3; j++) rd(2'd0, d);
        wr(2'd3, QS);
        base = sl_cnt; cs_rises = 0;
        for (int j = 0; j < 3; j++) wr(2'd1, 16'(8'hB0 + j));
        wait_bytes(base + 3);
        chk("R10 single cs rises", cs_rises, 3);
        chk("R10 single gap", cs_gap, 2 * 2 + 1);
        for (int j = 0; j < 3; j++) rd(2'd0, d);

        // R12 overfill queue then release
        wr(2'd3, 16'h0000);
        base = sl_cnt;
        for (int j = 0; j < 6; j++) wr(2'd1, 16'(8'hC0 + j));
        idle(60);
        chk("R9 no start with bit6 clear", sl_cnt, base);
        wr(2'd3, QS);
        wait_bytes(base + 4); idle(100);
        chk("R12 four bytes only", sl_cnt - base, 4);
        chk("R12 last kept", got[(base + 3) % 256], 8'hC3);
        for (int j = 0; j < 4; j++) rd(2'd0, d);

        // R6 transmit flush discards
        wr(2'd3, 16'h0000);
        base = sl_cnt;
        wr(2'd1, 16'h0077); wr(2'd1, 16'h0078);
        wr(2'd3, TF); wr(2'd1, 16'h0079);
        wr(2'd3, QS); idle(200);
        chk("R6 flushed nothing sent", sl_cnt, base);

        // R8 receive flush drops queued data
        base = sl_cnt;
        wr(2'd1, 16'h0031); wr(2'd1, 16'h0032);
        wait_bytes(base + 2);
        wr(2'd3, QS | RF);
        chk("R8 rx_irq low", rx_irq, 0);
        rd(2'd0, d); chk("R8 emptied", d, 0);

        // R7/R9 read-started fill bytes (last sent 0x32)
        wr(2'd3, TF | RF);
        base = sl_cnt;
        rd(2'd0, d);
        wait_bytes(base + 1);
        chk("R7 fill last", got[base % 256], 8'h32);
        wr(2'd3, TF | RF | ZF);
        rd(2'd0, d);
        wait_bytes(base + 2);
        chk("R7 fill zero", got[(base + 1) % 256], 8'h00);
        chk("R8 rx_irq while flush", rx_irq, 0);
        wr(2'd3, 16'h0000);
        rd(2'd0, d); chk("R8 dropped", d, 0);

        summary();
    end
endmodule